// File: doc/BRIEF.md
# Multi-mode ADC word serializer

This block turns one parallel converter sample per frame into a single serial bit stream that runs twelve ticks of a fast clock per frame, one bit per tick. With the serial bit it drives two companion clocks. The frame clock runs at the sample rate, and its rising edge marks the first bit of every word. The half-rate clock toggles on every bit, so a receiver can capture on both of its edges.

Besides live sample data, the stream can carry three built-in test words for receiver alignment. An alternating word lets the receiver find the bit-centre phase. A word of six zeros and six ones lets it find the frame boundary. A third word is assembled from three 4-bit custom nibbles. The bit order is selectable, and choosing most-significant-first reverses every one of these words. The source, the bit order, the sample and the nibbles are captured only at a frame boundary, so no frame ever mixes two sources.

Top module: `adc_word_serializer`

## Requirements
- R1: Each frame is 12 bit ticks long. `frame_clk_o` is high during bits 0..5 of a frame and low during bits 6..11.
- R2: The first bit of each word is on `ser_o` in the same tick that `frame_clk_o` goes high.
- R3: `half_clk_o` is high during even bit positions (0, 2, ..., 10) and low during odd positions, so it changes on every tick.
- R4: With `src_i` = 2'b00 and `msb_first_i` = 0, the frame sends `sample_i` bit 0 first and bit 11 last.
- R5: With `src_i` = 2'b00 and `msb_first_i` = 1, the frame sends `sample_i` bit 11 first and bit 0 last.
- R6: With `src_i` = 2'b01, the frame sends 1,0,1,0,... starting with 1 when LSB-first. When MSB-first, that sequence is sent reversed, starting with 0.
- R7: With `src_i` = 2'b10, the frame sends six 0s then six 1s when LSB-first, and six 1s then six 0s when MSB-first.
- R8: With `src_i` = 2'b11 and LSB-first, the frame sends `nib0_i` bits 0..3, then `nib1_i` bits 0..3, then `nib2_i` bits 0..3. When MSB-first, that 12-bit sequence is sent reversed.
- R9: The values of `sample_i`, `src_i`, `msb_first_i` and the nibbles are captured at the clock edge that ends bit 11. A change to any of them during a frame has no effect on that frame.
- R10: A synchronous active-high `rst` makes the next tick bit 0 of a new frame. That frame carries the inputs present at the last reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one tick per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 12 | Parallel converter sample |
| src_i | input | 2 | Output source: 00 data, 01 alternating, 10 frame-sync, 11 custom |
| msb_first_i | input | 1 | 0 sends least significant first, 1 reverses the order |
| nib0_i | input | 4 | Custom nibble sent first (LSB-first order) |
| nib1_i | input | 4 | Custom nibble sent second |
| nib2_i | input | 4 | Custom nibble sent last |
| ser_o | output | 1 | Serial bit |
| frame_clk_o | output | 1 | Frame clock at the sample rate, rising at bit 0 |
| half_clk_o | output | 1 | Clock at half the bit rate, one edge per bit |

## Verification
The hardest case to reach is an input change in the middle of a frame, because from the ports that change is only visible if the design wrongly lets it through. Every third frame, the stimulus scrambles the sample, source, order and nibbles at bit 5, then restores proper values just before the boundary. The reference model holds the word it captured at the previous boundary, so any leak shows up as a mismatch in bits 6..11. A reset asserted in the middle of a frame checks that the bit position restarts and that the values held during reset are the ones sent.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int WORD_W   = 12;
    localparam int CUST_W   = 4;
    localparam int NUM_CUST = 3;
    localparam int CNT_W    = $clog2(WORD_W);

    typedef enum logic [1:0] {
        SRC_DATA   = 2'b00,
        SRC_DESKEW = 2'b01,
        SRC_SYNC   = 2'b10,
        SRC_CUSTOM = 2'b11
    } src_e;

    typedef struct packed {
        src_e src;
        logic msb_first;
    } frame_cfg_t;

    // bit i of a word is the i-th bit on the wire in LSB-first order
    function automatic logic [WORD_W-1:0] reverse_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] alt_word();
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = ((i % 2) == 0);
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] step_word();
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = (i >= WORD_W/2);
        return r;
    endfunction

endpackage

// File: rtl/ser_frame_timer.sv
module ser_frame_timer #(
    parameter int WORD_W = ser_pkg::WORD_W,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] bit_idx,
    output logic             frame_end,
    output logic             frame_clk,
    output logic             half_clk
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign bit_idx   = cnt_q;
    assign frame_end = (cnt_q == LAST);
    assign frame_clk = (cnt_q < HALF);
    assign half_clk  = ~cnt_q[0];

endmodule

// File: rtl/ser_pattern_mux.sv
module ser_pattern_mux
    import ser_pkg::*;
#(
    parameter int WORD_W   = ser_pkg::WORD_W,
    parameter int CUST_W   = ser_pkg::CUST_W,
    parameter int NUM_CUST = ser_pkg::NUM_CUST
) (
    input  logic [WORD_W-1:0]                 sample,
    input  frame_cfg_t                        cfg,
    input  logic [NUM_CUST-1:0][CUST_W-1:0]   nibs,
    output logic [WORD_W-1:0]                 tx_word
);
    logic [WORD_W-1:0] cust_word;
    logic [WORD_W-1:0] lsb_word;

    // nibble 0 occupies the first wire positions
    for (genvar n = 0; n < NUM_CUST; n++) begin : g_cust
        assign cust_word[n*CUST_W +: CUST_W] = nibs[n];
    end

    always_comb begin
        unique case (cfg.src)
            SRC_DATA:   lsb_word = sample;
            SRC_DESKEW: lsb_word = alt_word();
            SRC_SYNC:   lsb_word = step_word();
            default:    lsb_word = cust_word;
        endcase
        tx_word = cfg.msb_first ? reverse_word(lsb_word) : lsb_word;
    end

endmodule

// File: rtl/ser_word_reg.sv
module ser_word_reg #(
    parameter int WORD_W = ser_pkg::WORD_W,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              load,
    input  logic [WORD_W-1:0] next_word,
    input  logic [CNT_W-1:0]  bit_idx,
    output logic [WORD_W-1:0] word_q,
    output logic              ser_bit
);
    always_ff @(posedge clk) begin
        if (load) word_q <= next_word;
    end

    assign ser_bit = word_q[bit_idx];

endmodule

// File: rtl/adc_word_serializer.sv
module adc_word_serializer
    import ser_pkg::*;
#(
    parameter int WORD_W   = ser_pkg::WORD_W,
    parameter int CUST_W   = ser_pkg::CUST_W,
    parameter int NUM_CUST = ser_pkg::NUM_CUST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] sample_i,
    input  logic [1:0]        src_i,
    input  logic              msb_first_i,
    input  logic [CUST_W-1:0] nib0_i,
    input  logic [CUST_W-1:0] nib1_i,
    input  logic [CUST_W-1:0] nib2_i,
    output logic              ser_o,
    output logic              frame_clk_o,
    output logic              half_clk_o
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [CNT_W-1:0]                bit_idx;
    logic                            frame_end;
    logic [WORD_W-1:0]               next_word;
    logic [WORD_W-1:0]               tx_word;
    logic [NUM_CUST-1:0][CUST_W-1:0] nibs;
    frame_cfg_t                      cfg;

    assign cfg.src       = src_e'(src_i);
    assign cfg.msb_first = msb_first_i;
    assign nibs[0]       = nib0_i;
    assign nibs[1]       = nib1_i;
    assign nibs[2]       = nib2_i;

    ser_frame_timer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .bit_idx   (bit_idx),
        .frame_end (frame_end),
        .frame_clk (frame_clk_o),
        .half_clk  (half_clk_o)
    );

    ser_pattern_mux #(.WORD_W(WORD_W), .CUST_W(CUST_W), .NUM_CUST(NUM_CUST)) u_mux (
        .sample  (sample_i),
        .cfg     (cfg),
        .nibs    (nibs),
        .tx_word (next_word)
    );

    ser_word_reg #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_word (
        .clk       (clk),
        .load      (rst | frame_end),
        .next_word (next_word),
        .bit_idx   (bit_idx),
        .word_q    (tx_word),
        .ser_bit   (ser_o)
    );

endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
    parameter int WORD_W = 12,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  bit_idx,
    input logic [WORD_W-1:0] tx_word,
    input logic              frame_clk_o,
    input logic              half_clk_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] HLST = CNT_W'(WORD_W / 2 - 1);

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        bit_idx == LAST |=> bit_idx == '0);

    // R1
    frame_step_chk: assert property (@(posedge clk) disable iff (rst)
        bit_idx != LAST |=> bit_idx == $past(bit_idx) + 1'b1);

    // R1
    frame_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_clk_o && bit_idx == HLST) |=> !frame_clk_o);

    // R2
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_clk_o) |-> bit_idx == '0);

    // R3
    half_fall_chk: assert property (@(posedge clk) disable iff (rst)
        half_clk_o |=> !half_clk_o);

    // R3
    half_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !half_clk_o |=> half_clk_o);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bit_idx != LAST |=> $stable(tx_word));

endmodule

bind adc_word_serializer ser_checker #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_idx     (bit_idx),
    .tx_word     (tx_word),
    .frame_clk_o (frame_clk_o),
    .half_clk_o  (half_clk_o)
);

// File: tb/adc_word_serializer_tb.sv
module adc_word_serializer_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic [11:0] sample;
    logic [1:0]  src;
    logic        msb;
    logic [3:0]  n0, n1, n2;
    logic        ser, fclk, hclk;

    adc_word_serializer u_dut (
        .clk(clk), .rst(rst), .sample_i(sample), .src_i(src), .msb_first_i(msb),
        .nib0_i(n0), .nib1_i(n1), .nib2_i(n2),
        .ser_o(ser), .frame_clk_o(fclk), .half_clk_o(hclk)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    int          k = 0;
    logic [11:0] expw = '0;
    logic [1:0]  fsrc = 2'b00;
    logic        fmsb = 1'b0;
    bit          rst_frame = 0;
    bit          mid_frame = 0;
    bit          started = 0;

    function automatic logic [11:0] build(input logic [1:0] s, input logic m,
                                          input logic [11:0] d, input logic [3:0] a,
                                          input logic [3:0] b, input logic [3:0] c);
        logic [11:0] w;
        for (int i = 0; i < 12; i++) begin
            int idx;
            idx = m ? 11 - i : i;
            case (s)
                2'b00: w[i] = d[idx];
                2'b01: w[i] = (idx % 2 == 0);
                2'b10: w[i] = (idx >= 6);
                default: w[i] = (idx < 4) ? a[idx] : (idx < 8) ? b[idx-4] : c[idx-8];
            endcase
        end
        return w;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst || k == 11) begin
            k         = 0;
            expw      = build(src, msb, sample, n0, n1, n2);
            fsrc      = src;
            fmsb      = msb;
            mid_frame = 0;
            rst_frame = rst;
        end else begin
            k++;
        end
    end

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at bit %0d: actual=%b expected=%b", req, what, k, act, exp);
        end
    endtask

    task automatic compare();
        string tag;
        if (rst_frame)                 tag = "R10";
        else if (mid_frame && k >= 6)  tag = "R9";
        else case (fsrc)
            2'b00: tag = fmsb ? "R5" : "R4";
            2'b01: tag = "R6";
            2'b10: tag = "R7";
            default: tag = "R8";
        endcase
        check(ser, expw[k], tag, "serial bit");
        check(fclk, (k < 6), (k == 0) ? "R2" : "R1", "frame clock");
        check(hclk, (k % 2 == 0), "R3", "half clock");
    endtask

    task automatic set_frame(input int f);
        src    = 2'(f % 4);
        msb    = 1'((f / 4) % 2);
        sample = (f % 5 == 0) ? 12'h801 : 12'($urandom);
        n0     = 4'($urandom);
        n1     = (f % 7 == 0) ? 4'hA : 4'($urandom);
        n2     = 4'($urandom);
    endtask

    initial begin
        int f;
        f   = 0;
        rst = 1'b1;
        set_frame(f);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int cyc = 0; cyc < 4800; cyc++) begin
            @(negedge clk);
            if (started) compare();
            if (cyc == 2000) rst = 1'b1;
            if (cyc == 2002) rst = 1'b0;
            if (k == 11) begin
                f++;
                set_frame(f);
            end else if (k == 5 && (f % 3) == 2 && !rst) begin
                // mid-frame scramble must not reach the current frame (R9)
                sample    = ~sample;
                src       = ~src;
                msb       = ~msb;
                n0        = ~n0;
                n1        = ~n1;
                n2        = ~n2;
                mid_frame = 1;
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule